// File: doc/BRIEF.md
# Sidetone Filter Control Registers

This block is the software-facing register file for an audio sidetone filter. A processor reaches it over a plain 32-bit bus made of a byte address, a write strobe with write data, and a read strobe with read data. It keeps the settings the filter datapath needs: a run switch, a bit that permits clock gating while idle, a signed 16-bit gain for each of two channels, and a bank of 128 signed 16-bit filter taps. Each of these drives an output port, so the filter reads them directly.

The taps do not each have their own address. Software sets a load-enable bit and then writes all 128 taps, one after another, to a single data port. An internal index places each word in order. Once the last tap is stored, a done flag rises and an interrupt status bit is set. Software polls the flag or takes the interrupt, then clears the load enable.

A fresh rising edge of the load enable always restarts the load at tap 0. An interrupted or partial load is therefore recovered by clearing the enable and setting it again.

Top module: `sidetone_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero except the identification word, and the run, idle-gate, gain and interrupt outputs are zero.
- R2: The identification word at byte offset 0x00 always reads the parameter REV_VALUE (default 0x00020001), and writes to it change nothing.
- R3: Read data is combinational while the read strobe is high, and is zero while the strobe is low. Offsets other than 0x00, 0x10, 0x18, 0x1C, 0x24, 0x28 and 0x2C read zero, and the tap data port (0x28) also reads zero.
- R4: Bit 0 of the power register (0x10) is read/write and drives the idle-gate output. The other bits of that register read zero.
- R5: The gain register (0x24) is read/write. Bits 15:0 drive the channel 0 gain output and bits 31:16 drive the channel 1 gain output, each taken as signed.
- R6: In the mode register (0x2C), bit 0 is the run switch and drives the run output, and bit 1 is the tap-load enable. Bit 2 is the read-only load-done flag, and writes to bit 2 are ignored.
- R7: While the load enable is set, each write to the data port stores write-data bits 15:0 as the next tap and advances the index. Tap k appears on bits 16k+15:16k of the tap output.
- R8: The done flag reads 1 from the cycle after the 128th accepted tap write. It stays 1 until the load enable is cleared, and it reads 0 once the enable is clear.
- R9: A data-port write made while the load enable is clear, or after 128 taps have been accepted, leaves every tap unchanged.
- R10: Writing the load enable from 0 to 1 restarts loading at tap 0. Writing 1 while it is already 1 keeps the current index.
- R11: Bit 0 of the event register (0x18) is set by load completion and cleared by writing 1 to it. Writing 0 leaves it set. The irq output is high while any event bit and its mask bit are both 1.
- R12: Bit 0 of the mask register (0x1C) is read/write and gates the matching event bit onto irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | BUS_W (32) | Read data, valid while bus_rd is high |
| tone_on | output | 1 | Sidetone run switch |
| idle_gate_ok | output | 1 | Clock gating permitted while idle |
| gain_ch0 | output | TAP_W (16) | Signed gain for channel 0 |
| gain_ch1 | output | TAP_W (16) | Signed gain for channel 1 |
| taps_flat | output | N_TAPS*TAP_W (2048) | All filter taps, tap k at bits 16k+15:16k |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a single bus master that makes at most one access per cycle and never raises the read and write strobes together. This rules out a data-port write and a mode or mask write landing in the same cycle.

The stimulus drives every access through one write task and one read task, each holding one strobe for one cycle. As a result, a load completion can never meet a competing event-clear or mask write.

Tap values come from a seeded arithmetic pattern that the bench recomputes. Every full load is then compared entry by entry against all 128 slices of the tap output.

// File: rtl/sidetone_pkg.sv
`timescale 1ns/1ps
package sidetone_pkg;

  localparam int unsigned OFS_ID    = 'h00;
  localparam int unsigned OFS_PWR   = 'h10;
  localparam int unsigned OFS_EVT   = 'h18;
  localparam int unsigned OFS_MASK  = 'h1C;
  localparam int unsigned OFS_LEVEL = 'h24;
  localparam int unsigned OFS_TAP   = 'h28;
  localparam int unsigned OFS_MODE  = 'h2C;

  localparam int unsigned MODE_RUN_BIT  = 0;
  localparam int unsigned MODE_LOAD_BIT = 1;
  localparam int unsigned MODE_DONE_BIT = 2;
  localparam int unsigned PWR_IDLE_BIT  = 0;
  localparam int unsigned EVT_DONE_BIT  = 0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ID, SEL_PWR, SEL_EVT, SEL_MASK, SEL_LEVEL, SEL_TAP, SEL_MODE
  } reg_sel_e;

  // write-one-to-clear update with set taking priority
  function automatic logic w1c_bit(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/sidetone_decode.sv
`timescale 1ns/1ps
module sidetone_decode
  import sidetone_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_ID))    sel = SEL_ID;
    else if (addr == ADDR_W'(OFS_PWR))   sel = SEL_PWR;
    else if (addr == ADDR_W'(OFS_EVT))   sel = SEL_EVT;
    else if (addr == ADDR_W'(OFS_MASK))  sel = SEL_MASK;
    else if (addr == ADDR_W'(OFS_LEVEL)) sel = SEL_LEVEL;
    else if (addr == ADDR_W'(OFS_TAP))   sel = SEL_TAP;
    else if (addr == ADDR_W'(OFS_MODE))  sel = SEL_MODE;
  end

endmodule

// File: rtl/sidetone_tap_loader.sv
`timescale 1ns/1ps
module sidetone_tap_loader #(
  parameter int unsigned N_TAPS = 128,
  parameter int unsigned TAP_W  = 16,
  localparam int unsigned IDX_W = $clog2(N_TAPS + 1),
  localparam int unsigned MEM_AW = (N_TAPS > 1) ? $clog2(N_TAPS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_en,
  input  logic                      load_start,
  input  logic                      load_stop,
  input  logic                      tap_wr,
  input  logic [TAP_W-1:0]          tap_data,
  output logic [N_TAPS*TAP_W-1:0]   taps_flat,
  output logic [IDX_W-1:0]          tap_index,
  output logic                      load_done,
  output logic                      tap_accept,
  output logic                      load_finish
);

  logic [TAP_W-1:0] mem [N_TAPS];
  logic             idx_full;

  assign idx_full    = (tap_index == IDX_W'(N_TAPS));
  assign tap_accept  = tap_wr & load_en & ~idx_full;
  assign load_finish = tap_accept & (tap_index == IDX_W'(N_TAPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_index <= '0;
      load_done <= 1'b0;
    end else if (load_start || load_stop) begin
      tap_index <= '0;
      load_done <= 1'b0;
    end else if (tap_accept) begin
      tap_index <= tap_index + 1'b1;
      if (load_finish) load_done <= 1'b1;
    end
  end

  // contents are undefined until a load completes, so no reset
  always_ff @(posedge clk) begin
    if (tap_accept) mem[tap_index[MEM_AW-1:0]] <= tap_data;
  end

  for (genvar k = 0; k < N_TAPS; k++) begin : g_flat
    assign taps_flat[k*TAP_W +: TAP_W] = mem[k];
  end

endmodule

// File: rtl/sidetone_evt_unit.sv
`timescale 1ns/1ps
module sidetone_evt_unit
  import sidetone_pkg::*;
#(
  parameter int unsigned N_EVT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_set,
  input  logic             stat_wr,
  input  logic             mask_wr,
  input  logic [N_EVT-1:0] wbits,
  output logic [N_EVT-1:0] evt_status,
  output logic [N_EVT-1:0] evt_mask,
  output logic             irq
);

  for (genvar b = 0; b < N_EVT; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        evt_status[b] <= 1'b0;
        evt_mask[b]   <= 1'b0;
      end else begin
        evt_status[b] <= w1c_bit(evt_status[b], evt_set[b], stat_wr & wbits[b]);
        if (mask_wr) evt_mask[b] <= wbits[b];
      end
    end
  end

  assign irq = |(evt_status & evt_mask);

endmodule

// File: rtl/sidetone_ctrl_regs.sv
`timescale 1ns/1ps
module sidetone_ctrl_regs
  import sidetone_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned N_TAPS    = 128,
  parameter int unsigned TAP_W     = 16,
  parameter int unsigned N_EVT     = 1,
  parameter logic [31:0] REV_VALUE = 32'h0002_0001,
  localparam int unsigned IDX_W    = $clog2(N_TAPS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [BUS_W-1:0]         bus_wdata,
  input  logic                     bus_rd,
  output logic [BUS_W-1:0]         bus_rdata,
  output logic                     tone_on,
  output logic                     idle_gate_ok,
  output logic signed [TAP_W-1:0]  gain_ch0,
  output logic signed [TAP_W-1:0]  gain_ch1,
  output logic [N_TAPS*TAP_W-1:0]  taps_flat,
  output logic                     irq
);

  reg_sel_e             sel;
  logic                 pwr_q;
  logic [2*TAP_W-1:0]   level_q;
  logic                 run_q;
  logic                 load_q;
  logic                 pwr_wr, level_wr, mode_wr, tap_wr, evt_wr, mask_wr;
  logic                 load_start, load_stop;
  logic                 tap_accept, load_finish, load_done;
  logic [IDX_W-1:0]     tap_index;
  logic [N_EVT-1:0]     evt_status, evt_mask, evt_set;

  sidetone_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  assign pwr_wr   = bus_wr & (sel == SEL_PWR);
  assign level_wr = bus_wr & (sel == SEL_LEVEL);
  assign mode_wr  = bus_wr & (sel == SEL_MODE);
  assign tap_wr   = bus_wr & (sel == SEL_TAP);
  assign evt_wr   = bus_wr & (sel == SEL_EVT);
  assign mask_wr  = bus_wr & (sel == SEL_MASK);

  // edges of the load enable, seen as events
  assign load_start = mode_wr &  bus_wdata[MODE_LOAD_BIT] & ~load_q;
  assign load_stop  = mode_wr & ~bus_wdata[MODE_LOAD_BIT] &  load_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      level_q <= '0;
      run_q   <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      if (pwr_wr)   pwr_q   <= bus_wdata[PWR_IDLE_BIT];
      if (level_wr) level_q <= bus_wdata[2*TAP_W-1:0];
      if (mode_wr) begin
        run_q  <= bus_wdata[MODE_RUN_BIT];
        load_q <= bus_wdata[MODE_LOAD_BIT];
      end
    end
  end

  sidetone_tap_loader #(.N_TAPS(N_TAPS), .TAP_W(TAP_W)) u_load (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_q), .load_start(load_start), .load_stop(load_stop),
    .tap_wr(tap_wr), .tap_data(bus_wdata[TAP_W-1:0]),
    .taps_flat(taps_flat), .tap_index(tap_index), .load_done(load_done),
    .tap_accept(tap_accept), .load_finish(load_finish)
  );

  always_comb begin
    evt_set = '0;
    evt_set[EVT_DONE_BIT] = load_finish;
  end

  sidetone_evt_unit #(.N_EVT(N_EVT)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .stat_wr(evt_wr), .mask_wr(mask_wr), .wbits(bus_wdata[N_EVT-1:0]),
    .evt_status(evt_status), .evt_mask(evt_mask), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_ID:    bus_rdata = BUS_W'(REV_VALUE);
        SEL_PWR:   bus_rdata[PWR_IDLE_BIT] = pwr_q;
        SEL_EVT:   bus_rdata = BUS_W'(evt_status);
        SEL_MASK:  bus_rdata = BUS_W'(evt_mask);
        SEL_LEVEL: bus_rdata = BUS_W'(level_q);
        SEL_MODE: begin
          bus_rdata[MODE_RUN_BIT]  = run_q;
          bus_rdata[MODE_LOAD_BIT] = load_q;
          bus_rdata[MODE_DONE_BIT] = load_done;
        end
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign tone_on      = run_q;
  assign idle_gate_ok = pwr_q;
  assign gain_ch0     = level_q[TAP_W-1:0];
  assign gain_ch1     = level_q[2*TAP_W-1:TAP_W];

endmodule

// File: rtl/sidetone_ctrl_checker.sv
`timescale 1ns/1ps
module sidetone_ctrl_checker
  import sidetone_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned N_EVT  = 1,
  parameter int unsigned IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              load_q,
  input logic              load_start,
  input logic              load_stop,
  input logic              tap_accept,
  input logic              load_finish,
  input logic              load_done,
  input logic [IDX_W-1:0]  tap_index,
  input logic [N_EVT-1:0]  evt_status,
  input logic [N_EVT-1:0]  evt_mask,
  input logic              irq
);

  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(OFS_ID))   || (bus_addr == ADDR_W'(OFS_PWR))  ||
                  (bus_addr == ADDR_W'(OFS_EVT))  || (bus_addr == ADDR_W'(OFS_MASK)) ||
                  (bus_addr == ADDR_W'(OFS_LEVEL))|| (bus_addr == ADDR_W'(OFS_MODE));

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !mapped) |-> (bus_rdata == '0));

  p_accept_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_accept |-> load_q);

  p_full_blocks_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !tap_accept);

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_finish |=> load_done);

  p_done_drop_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_done) |-> $past(load_stop) || $past(load_start));

  p_restart_at_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> (tap_index == '0));

  p_irq_on_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_finish && evt_mask[EVT_DONE_BIT]) |=> irq);

  p_w1c_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_EVT) && bus_wdata[EVT_DONE_BIT] && !load_finish)
      |=> !evt_status[EVT_DONE_BIT]);

  p_irq_needs_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(evt_mask & evt_status));

endmodule

bind sidetone_ctrl_regs sidetone_ctrl_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .N_EVT(N_EVT), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .load_q(load_q), .load_start(load_start), .load_stop(load_stop),
  .tap_accept(tap_accept), .load_finish(load_finish), .load_done(load_done),
  .tap_index(tap_index), .evt_status(evt_status), .evt_mask(evt_mask), .irq(irq)
);

// File: tb/tb_sidetone_ctrl_regs.sv
`timescale 1ns/1ps
module tb_sidetone_ctrl_regs;

  localparam int NT = 128;
  localparam logic [31:0] REV = 32'h0002_0001;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_rdata;
  logic              tone_on, idle_gate_ok, irq;
  logic signed [15:0] gain_ch0, gain_ch1;
  logic [NT*16-1:0]  taps_flat;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sidetone_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tone_on(tone_on), .idle_gate_ok(idle_gate_ok), .gain_ch0(gain_ch0),
    .gain_ch1(gain_ch1), .taps_flat(taps_flat), .irq(irq)
  );

  function automatic logic [15:0] tap_val(input int k, input int seed);
    return 16'((k * 613 + seed * 4099 + 32768) & 32'hFFFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic load_taps(input int first, input int last, input int seed);
    for (int k = first; k <= last; k++) wr(8'h28, {16'hA5A5, tap_val(k, seed)});
  endtask

  task automatic chk_taps(input string tag, input int seed);
    for (int k = 0; k < NT; k++) chk(tag, 32'(taps_flat[k*16 +: 16]), 32'(tap_val(k, seed)));
  endtask

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 id", 8'h00, REV);
    rd_chk("R1 pwr", 8'h10, 0);
    rd_chk("R1 evt", 8'h18, 0);
    rd_chk("R1 mask", 8'h1C, 0);
    rd_chk("R1 gain", 8'h24, 0);
    rd_chk("R1 mode", 8'h2C, 0);
    chk("R1 outputs", {28'd0, tone_on, idle_gate_ok, irq, 1'b0}, 0);
    chk("R1 gains", {gain_ch1, gain_ch0}, 0);

    // R2 identification word ignores writes
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R2 id after write", 8'h00, REV);

    // R3 unmapped offsets, tap port and idle strobe read zero
    wr(8'h04, 32'h1234_5678);
    rd_chk("R3 unmapped 0x04", 8'h04, 0);
    rd_chk("R3 unmapped 0x01", 8'h01, 0);
    rd_chk("R3 unmapped 0xFC", 8'hFC, 0);
    rd_chk("R3 tap port", 8'h28, 0);
    @(negedge clk); bus_addr = 8'h00; #1 chk("R3 no strobe", bus_rdata, 0);

    // R4 power register
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R4 pwr set", 8'h10, 1);
    chk("R4 idle output", 32'(idle_gate_ok), 1);
    wr(8'h10, 0);
    rd_chk("R4 pwr clear", 8'h10, 0);
    chk("R4 idle output clear", 32'(idle_gate_ok), 0);

    // R5 gain sweep
    for (int i = 0; i < 16; i++) begin
      v = 32'(i) * 32'h1357_9BDF ^ 32'h8001_7FFF;
      wr(8'h24, v);
      rd_chk("R5 gain readback", 8'h24, v);
      chk("R5 ch0", 32'(signed'(gain_ch0)), 32'(signed'(v[15:0])));
      chk("R5 ch1", 32'(signed'(gain_ch1)), 32'(signed'(v[31:16])));
    end

    // R6 run bit, done bit not writable
    wr(8'h2C, 32'h5);
    rd_chk("R6 mode run only", 8'h2C, 1);
    chk("R6 tone_on", 32'(tone_on), 1);

    // R12 mask
    wr(8'h1C, 1);
    rd_chk("R12 mask", 8'h1C, 1);

    // R7 R8 R11 full load
    wr(8'h2C, 3);
    load_taps(0, NT - 2, 1);
    rd_chk("R8 not done at 127", 8'h2C, 3);
    chk("R11 irq low before done", 32'(irq), 0);
    load_taps(NT - 1, NT - 1, 1);
    rd_chk("R8 done after 128", 8'h2C, 7);
    chk("R11 irq high", 32'(irq), 1);
    rd_chk("R11 evt set", 8'h18, 1);
    chk_taps("R7 taps seed1", 1);

    // R9 writes past the end are ignored
    wr(8'h28, 32'h0000_1111);
    chk_taps("R9 full ignores", 1);
    rd_chk("R8 done holds", 8'h2C, 7);

    // R11 write 0 keeps, write 1 clears
    wr(8'h18, 0);
    rd_chk("R11 write zero keeps", 8'h18, 1);
    wr(8'h18, 1);
    rd_chk("R11 w1c", 8'h18, 0);
    chk("R11 irq cleared", 32'(irq), 0);

    // R8 clearing enable clears done; R9 writes while clear ignored
    wr(8'h2C, 1);
    rd_chk("R8 done cleared", 8'h2C, 1);
    wr(8'h28, 32'h0000_2222);
    chk_taps("R9 disabled ignores", 1);

    // R10 restart on rising enable
    wr(8'h2C, 3);
    load_taps(0, 9, 2);
    wr(8'h2C, 1);
    wr(8'h2C, 3);
    load_taps(0, NT - 1, 3);
    rd_chk("R10 restart done", 8'h2C, 7);
    chk_taps("R10 restart taps", 3);

    // R10 rewriting 1 keeps the index
    wr(8'h2C, 1);
    wr(8'h2C, 3);
    load_taps(0, 4, 4);
    wr(8'h2C, 3);
    load_taps(5, NT - 1, 4);
    rd_chk("R10 no restart done", 8'h2C, 7);
    chk_taps("R10 no restart taps", 4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule